// File: doc/BRIEF.md
# Serial Display-Controller Register Writer

This block programs the registers of a display controller over a write-only SPI link. The host gives it a command code, an 8-bit register number, a 16-bit value and a set of user orientation and color-order bits. The block then sends one or more register writes. Each register write is two chip-select frames of 24 bits. The first frame selects the register and the second frame carries the value.

Besides a plain single write, three built-in command sequences exist. Power-up leaves shutdown and then loads the output-control word. Shutdown puts the controller into its shutdown state. Resume loads the output-control word first and then leaves shutdown. The output-control word merges the user bits, under a mask, with a fixed default for every other bit. The mask is a build parameter.

The host side uses a plain start/busy/done handshake and has no back-pressure. A start pulse is accepted only while the block is idle. A start that arrives while the block is busy is dropped and is never queued. The block drives SCLK, MOSI and an active-low chip select.

Top module: `panel_spi_writer`

## Requirements
- R1: The register-select frame carries the bytes 0x74, 0x00 and then the register number, in that order.
- R2: The value frame carries the byte 0x76, then the high byte of the value, then the low byte of the value.
- R3: Within each register write, the register-select frame goes out before the value frame. Chip select goes high between any two frames, and chip select stays high whenever the block is not busy.
- R4: Each low period of chip select holds exactly 24 SCLK rising edges. Bits go out MSB first in SPI mode 0: SCLK is low while idle, and MOSI changes only while SCLK is low.
- R5: The command code on `op` is encoded as follows: 0 = single write of `wr_value` to `reg_addr`, 1 = power-up, 2 = shutdown, 3 = resume.
- R6: Power-up writes 0x0000 to register 0x11 and then writes the output-control word to register 0x01.
- R7: Shutdown writes 0x0001 to register 0x11.
- R8: Resume writes the output-control word to register 0x01 and then writes 0x0000 to register 0x11.
- R9: The output-control word is (user_mode AND MODE_MASK) OR (0x2AEF AND NOT MODE_MASK). It is taken from `user_mode` in the cycle the start is accepted.
- R10: `busy` rises in the cycle after an accepted start and stays high until the last frame completes. `done` is a one-cycle pulse, and it occurs in the same cycle that `busy` falls.
- R11: A start that arrives while `busy` is high is ignored. The running command completes unchanged, and no extra frames are sent.
- R12: One SCLK period lasts 2*CLK_DIV system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command request, sampled while idle |
| op | input | 2 | Command code (R5) |
| reg_addr | input | 8 | Register number for a single write |
| wr_value | input | 16 | Value for a single write |
| user_mode | input | 16 | User orientation and color-order bits |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse when a command ends |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | SPI data, MSB first |
| spi_cs_n | output | 1 | SPI chip select, active low |

## Verification
The bench builds the block with CLK_DIV = 2, which keeps every frame to about a hundred cycles. It still gives SCLK half periods of more than one clock, so the check that MOSI holds steady while SCLK is high has real cycles to observe. MODE_MASK is set to 0x0F0F, so the mask covers bits that are set in the fixed default and bits that are clear in it. A wrong merge in the output-control word then shows up in both directions. Frames are decoded at the pins, from the SCLK rising edges inside each chip-select window.

// File: rtl/panel_spi_pkg.sv
package panel_spi_pkg;
  typedef enum logic [1:0] {
    OP_WRITE    = 2'd0,
    OP_POWER_UP = 2'd1,
    OP_SHUTDOWN = 2'd2,
    OP_RESUME   = 2'd3
  } panel_op_e;

  localparam int          FRAME_BITS  = 24;
  localparam logic [7:0]  SEL_PREFIX  = 8'h74;
  localparam logic [7:0]  VAL_PREFIX  = 8'h76;
  localparam logic [7:0]  REG_SLEEP   = 8'h11;
  localparam logic [7:0]  REG_OUTCTL  = 8'h01;
  localparam logic [15:0] OUTCTL_BASE = 16'h2AEF;
  localparam logic [15:0] SLEEP_EXIT  = 16'h0000;
  localparam logic [15:0] SLEEP_ENTER = 16'h0001;
endpackage

// File: rtl/panel_spi_frame.sv
module panel_spi_frame #(
  parameter int CLK_DIV    = 4,
  parameter int FRAME_BITS = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [FRAME_BITS-1:0] data,
  output logic                  frame_done,
  output logic                  sclk,
  output logic                  mosi,
  output logic                  cs_n
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int CNT_W = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {F_IDLE, F_SHIFT, F_GAP} fstate_e;
  fstate_e               st;
  logic [DIV_W-1:0]      div_cnt;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic                  tick;

  assign tick = (div_cnt == DIV_W'(CLK_DIV - 1));
  assign mosi = shreg[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= F_IDLE;
      div_cnt    <= '0;
      bit_cnt    <= '0;
      shreg      <= '0;
      sclk       <= 1'b0;
      cs_n       <= 1'b1;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (st)
        F_IDLE: if (go) begin
          shreg   <= data;
          cs_n    <= 1'b0;
          sclk    <= 1'b0;
          div_cnt <= '0;
          bit_cnt <= '0;
          st      <= F_SHIFT;
        end
        F_SHIFT: begin
          div_cnt <= tick ? '0 : div_cnt + 1'b1;
          if (tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
                cs_n  <= 1'b1;
                shreg <= '0;
                st    <= F_GAP;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= shreg << 1;
              end
            end
          end
        end
        default: begin
          div_cnt <= tick ? '0 : div_cnt + 1'b1;
          if (tick) begin
            st         <= F_IDLE;
            frame_done <= 1'b1;
          end
        end
      endcase
    end
  end

  // R4: SCLK idles low outside a frame
  assert_sclk_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R4: data held while SCLK is high
  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R4: frame closes after the last bit only
  assert_frame_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> ($past(bit_cnt) == CNT_W'(FRAME_BITS - 1)));
endmodule

// File: rtl/panel_cmd_seq.sv
module panel_cmd_seq
  import panel_spi_pkg::*;
#(
  parameter logic [15:0] MODE_MASK = 16'hF000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            op,
  input  logic [7:0]            reg_addr,
  input  logic [15:0]           wr_value,
  input  logic [15:0]           user_mode,
  input  logic                  frame_done,
  output logic                  busy,
  output logic                  done,
  output logic                  frame_go,
  output logic [FRAME_BITS-1:0] frame_data
);
  panel_op_e   op_q;
  logic [7:0]  addr_q;
  logic [15:0] val_q;
  logic [15:0] mode_q;
  logic [1:0]  frame_idx;
  logic [1:0]  last_idx;
  logic [7:0]  cur_addr;
  logic [15:0] cur_val;

  // Pick the register write for the current frame pair
  always_comb begin
    cur_addr = addr_q;
    cur_val  = val_q;
    case (op_q)
      OP_POWER_UP: begin
        cur_addr = frame_idx[1] ? REG_OUTCTL : REG_SLEEP;
        cur_val  = frame_idx[1] ? mode_q : SLEEP_EXIT;
      end
      OP_SHUTDOWN: begin
        cur_addr = REG_SLEEP;
        cur_val  = SLEEP_ENTER;
      end
      OP_RESUME: begin
        cur_addr = frame_idx[1] ? REG_SLEEP : REG_OUTCTL;
        cur_val  = frame_idx[1] ? SLEEP_EXIT : mode_q;
      end
      default: ;
    endcase
    frame_data = frame_idx[0] ? {VAL_PREFIX, cur_val} : {SEL_PREFIX, 8'h00, cur_addr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= OP_WRITE;
      addr_q    <= '0;
      val_q     <= '0;
      mode_q    <= '0;
      frame_idx <= '0;
      last_idx  <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      frame_go  <= 1'b0;
    end else begin
      done     <= 1'b0;
      frame_go <= 1'b0;
      if (!busy) begin
        if (start) begin
          op_q      <= panel_op_e'(op);
          addr_q    <= reg_addr;
          val_q     <= wr_value;
          mode_q    <= (user_mode & MODE_MASK) | (OUTCTL_BASE & ~MODE_MASK);
          last_idx  <= (op == OP_WRITE || op == OP_SHUTDOWN) ? 2'd1 : 2'd3;
          frame_idx <= '0;
          busy      <= 1'b1;
          frame_go  <= 1'b1;
        end
      end else if (frame_done) begin
        if (frame_idx == last_idx) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          frame_idx <= frame_idx + 1'b1;
          frame_go  <= 1'b1;
        end
      end
    end
  end

  // R11: a start during a command leaves the captured command untouched
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(op_q) && $stable(addr_q) && $stable(val_q)));
  // R10: busy ends only together with done
  assert_busy_ends_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R10: done lasts one cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/panel_spi_writer.sv
module panel_spi_writer #(
  parameter int          CLK_DIV   = 4,
  parameter logic [15:0] MODE_MASK = 16'hF000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [7:0]  reg_addr,
  input  logic [15:0] wr_value,
  input  logic [15:0] user_mode,
  output logic        busy,
  output logic        done,
  output logic        spi_sclk,
  output logic        spi_mosi,
  output logic        spi_cs_n
);
  import panel_spi_pkg::*;

  logic                  frame_go;
  logic                  frame_done;
  logic [FRAME_BITS-1:0] frame_data;

  panel_cmd_seq #(.MODE_MASK(MODE_MASK)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op         (op),
    .reg_addr   (reg_addr),
    .wr_value   (wr_value),
    .user_mode  (user_mode),
    .frame_done (frame_done),
    .busy       (busy),
    .done       (done),
    .frame_go   (frame_go),
    .frame_data (frame_data)
  );

  panel_spi_frame #(.CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (frame_go),
    .data       (frame_data),
    .frame_done (frame_done),
    .sclk       (spi_sclk),
    .mosi       (spi_mosi),
    .cs_n       (spi_cs_n)
  );

  // R3: no bus activity while idle
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);
endmodule

// File: tb/test_panel_spi_writer.sv
`timescale 1ns/1ps
module test_panel_spi_writer;
  localparam int          CLK_PERIOD = 10;
  localparam int          DIV        = 2;
  localparam logic [15:0] MASK       = 16'h0F0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] wr_value = '0;
  logic [15:0] user_mode = '0;
  logic        busy, done, spi_sclk, spi_mosi, spi_cs_n;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_spi_writer #(.CLK_DIV(DIV), .MODE_MASK(MASK)) i_panel_spi_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .reg_addr(reg_addr),
    .wr_value(wr_value), .user_mode(user_mode), .busy(busy), .done(done),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n));

  // Pin-level frame decoder
  logic [23:0] frames [0:7];
  int          fbits  [0:7];
  int          nframes = 0;
  logic [23:0] shifter;
  int          bitcnt;
  realtime     last_rise, rise_gap;
  int          mode_err = 0;
  logic        prev_sclk = 1'b0, prev_mosi = 1'b0;

  always @(negedge spi_cs_n) begin shifter = '0; bitcnt = 0; end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    shifter = {shifter[22:0], spi_mosi};
    if (bitcnt > 0) rise_gap = $realtime - last_rise;
    last_rise = $realtime;
    bitcnt++;
  end
  always @(posedge spi_cs_n) if (rst_n && nframes < 8) begin
    frames[nframes] = shifter; fbits[nframes] = bitcnt; nframes++;
  end
  always @(negedge clk) begin
    if (spi_sclk && prev_sclk && spi_mosi !== prev_mosi) mode_err++;
    if (spi_cs_n && spi_sclk) mode_err++;
    prev_sclk = spi_sclk; prev_mosi = spi_mosi;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] outctl(input logic [15:0] u);
    return (u & MASK) | (16'h2AEF & ~MASK);
  endfunction

  task automatic check_write(input int idx, input logic [7:0] a, input logic [15:0] v, input string req);
    check(frames[idx] === {8'h74, 8'h00, a}, "R1", {req, " select frame"}, 32'(frames[idx]), {8'h74, 8'h00, a});
    check(frames[idx+1] === {8'h76, v}, "R2", {req, " value frame"}, 32'(frames[idx+1]), {8'h76, v});
    check(fbits[idx] == 24 && fbits[idx+1] == 24, "R4", {req, " bits per frame"}, 32'(fbits[idx]), 32'd24);
  endtask

  task automatic run_cmd(input logic [1:0] o, input logic [7:0] a, input logic [15:0] v,
                         input logic [15:0] u, input int interfere);
    nframes = 0; mode_err = 0;
    @(negedge clk);
    op = o; reg_addr = a; wr_value = v; user_mode = u; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R10", "busy after start", 32'(busy), 32'd1);
    if (interfere > 0) begin
      repeat (interfere) @(negedge clk);
      op = 2'd1; reg_addr = 8'hEE; wr_value = 16'hDEAD; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);
    check(busy === 1'b0, "R10", "busy low at done", 32'(busy), 32'd0);
    @(negedge clk);
    check(done === 1'b0, "R10", "done one cycle", 32'(done), 32'd0);
    check(spi_cs_n === 1'b1, "R3", "cs high when idle", 32'(spi_cs_n), 32'd1);
    check(mode_err == 0, "R4", "mode 0 violations", 32'(mode_err), 32'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check(busy === 1'b0 && done === 1'b0, "R10", "reset busy/done", {30'd0, busy, done}, 32'd0);
    check(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R4", "reset cs/sclk", {30'd0, spi_cs_n, spi_sclk}, 32'd2);
  endtask

  task automatic t_single;
    run_cmd(2'd0, 8'h3C, 16'hA55A, 16'h0000, 0);
    check(nframes == 2, "R5", "single write frame count", 32'(nframes), 32'd2);
    check_write(0, 8'h3C, 16'hA55A, "R5 single");
    check(rise_gap == real'(2*DIV*CLK_PERIOD), "R12", "sclk period", 32'(int'(rise_gap)), 32'(2*DIV*CLK_PERIOD));
    run_cmd(2'd0, 8'hC3, 16'h0180, 16'h0000, 0);
    check_write(0, 8'hC3, 16'h0180, "R3 second single");
  endtask

  task automatic t_power_up;
    run_cmd(2'd1, 8'h00, 16'h0000, 16'hFFFF, 0);
    check(nframes == 4, "R6", "power-up frame count", 32'(nframes), 32'd4);
    check_write(0, 8'h11, 16'h0000, "R6 leave shutdown");
    check_write(2, 8'h01, outctl(16'hFFFF), "R9 output word");
  endtask

  task automatic t_shutdown;
    run_cmd(2'd2, 8'h55, 16'h1234, 16'h0000, 0);
    check(nframes == 2, "R7", "shutdown frame count", 32'(nframes), 32'd2);
    check_write(0, 8'h11, 16'h0001, "R7 shutdown");
  endtask

  task automatic t_resume;
    run_cmd(2'd3, 8'h00, 16'h0000, 16'h0000, 0);
    check(nframes == 4, "R8", "resume frame count", 32'(nframes), 32'd4);
    check_write(0, 8'h01, outctl(16'h0000), "R8 R9 output word");
    check_write(2, 8'h11, 16'h0000, "R8 leave shutdown");
  endtask

  task automatic t_busy_start;
    run_cmd(2'd2, 8'h00, 16'h0000, 16'h0000, 20);
    check(nframes == 2, "R11", "frames with start while busy", 32'(nframes), 32'd2);
    check_write(0, 8'h11, 16'h0001, "R11 unchanged");
    check(busy === 1'b0, "R11", "no restart", 32'(busy), 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single();
    t_power_up();
    t_shutdown();
    t_resume();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule